// File: doc/BRIEF.md
# Buffered Factory Program Sequencer

This block runs the bulk factory-program mode of a 16-bit-wide NOR-style flash array on the device side. After a single-cycle `mode_enter` pulse, the host issues plain bus writes. The first write fixes the start address and supplies the first data word. Each later write in the same block supplies only data. The sequencer stores these words in a 32-slot write buffer, using its own counter to pick the slot. When the buffer is full, it drives each word into the array through a request/acknowledge port. Every word is programmed, read back and compared, and programming is repeated until the word matches or the retry budget is used up.

After a buffer has been programmed, the host may fill another 32 words without entering the mode again. The array location keeps advancing from where the previous buffer stopped. A write whose address lies in a different block closes the phase, and the block then reports read-status again. The status byte gives the host four flags:

- a per-word busy flag, which the host polls before each write;
- an exit flag;
- a sticky sequence-error flag;
- a sticky program-failure flag.

Top module: `fpgm_seq`

## Requirements
- R1: After reset the status byte reads 8'h80: bit 7 (exit/read-status) is 1, bit 0 (busy) is 0, and no array request is raised.
- R2: After `mode_enter` the first bus write captures the start address and stores its data in slot 0. The data of slot k goes to array address start + offset + k, where offset is 0 for the first buffer.
- R3: Words fill buffer slots 0..31 in write order. The write that fills slot 31 sets status bit 0 to 1 in the next cycle, and the 32 words are then programmed in slot order.
- R4: Data writes inside the start block whose low address bits differ from the start address are still stored at the counter position. The block is the address bits at and above BLK_BITS (bits 19:16 by default).
- R5: Once a buffer is programmed, status bit 0 returns to 0. The next 32-word fill goes to array offsets 32 higher than the previous buffer.
- R6: Each word is programmed, read back and compared. On a mismatch it is reprogrammed, up to MAX_TRIES (default 4) program operations in total. If it still mismatches, sticky status bit 4 is set and programming moves on to the next word.
- R7: A bus write while status bit 0 is 1 is not stored and does not advance the slot counter. It sets sticky status bit 3.
- R8: A bus write outside the start block during a fill ends the phase. Status bit 7 becomes 1 and bit 0 becomes 0, the write is not stored, and any partly filled buffer is dropped without array operations.
- R9: While status bit 7 is 1, bus writes are ignored: no array operations and no status change.
- R10: `mode_enter` while status bit 7 is 1 clears sticky bits 3 and 4, so the status reads 8'h00.
- R11: An array request holds `arr_req`, `arr_we`, `arr_addr` and `arr_wdata` stable until `arr_ack`. `arr_we` = 1 means program, where cells only clear bits; 0 means read.
- R12: Filler words of 16'hFFFF are programmed like any other data and leave erased cells at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_enter | input | 1 | Pulse that starts the factory-program mode |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | AW | Bus write address |
| bus_wdata | input | DW | Bus write data |
| status | output | 8 | Status: bit 0 busy, bit 3 sequence error, bit 4 program failure, bit 7 exit |
| arr_req | output | 1 | Array operation request |
| arr_we | output | 1 | 1 = program, 0 = read |
| arr_addr | output | AW | Array word address |
| arr_wdata | output | DW | Program data |
| arr_ack | input | 1 | Array operation complete |
| arr_rdata | input | DW | Read data, valid with `arr_ack` |

## Verification
The hardest situations to reach are the retry paths, because a healthy array matches on the first program. The bench's array model therefore has one word that drops its first two program operations and one word with a bit stuck at zero. This drives the retry loop through both of its exits: one recovers, the other hits the retry limit. A write while busy is produced by issuing a bus write without polling, right after the write that fills slot 31. The following fill is then checked to confirm that slot 0 was not taken.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

   typedef enum logic [1:0] {
      SQ_OFF,
      SQ_FIRST,
      SQ_FILL,
      SQ_PROG
   } seq_st_t;

   typedef enum logic [1:0] {
      PV_IDLE,
      PV_WR,
      PV_RD,
      PV_CHK
   } pv_st_t;

   localparam int SB_BUSY = 0;
   localparam int SB_SEQ  = 3;
   localparam int SB_FAIL = 4;
   localparam int SB_EXIT = 7;

endpackage

// File: rtl/fpgm_wbuf.sv
module fpgm_wbuf #(
   parameter int DW    = 16,
   parameter int DEPTH = 32,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] slot_q [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[s] <= '1;
         else if (wr_en && wr_idx == IW'(s))
            slot_q[s] <= wr_data;
      end
   end

   assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/fpgm_blkcmp.sv
module fpgm_blkcmp #(
   parameter int HW = 4
) (
   input  logic [HW-1:0] hi_a,
   input  logic [HW-1:0] hi_b,
   output logic          same
);

   assign same = (hi_a == hi_b);

endmodule

// File: rtl/fpgm_pv.sv
module fpgm_pv
   import fpgm_pkg::*;
#(
   parameter int AW        = 20,
   parameter int DW        = 16,
   parameter int DEPTH     = 32,
   parameter int MAX_TRIES = 4,
   localparam int IW       = $clog2(DEPTH),
   localparam int TW       = $clog2(MAX_TRIES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] base_addr,
   output logic [IW-1:0] rd_idx,
   input  logic [DW-1:0] rd_data,
   output logic          arr_req,
   output logic          arr_we,
   output logic [AW-1:0] arr_addr,
   output logic [DW-1:0] arr_wdata,
   input  logic          arr_ack,
   input  logic [DW-1:0] arr_rdata,
   output logic          done,
   output logic          fail
);

   localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);
   localparam logic [TW-1:0] TRY_LIM  = TW'(MAX_TRIES);

   pv_st_t        st_q;
   logic [IW-1:0] idx_q;
   logic [TW-1:0] tries_q;
   logic [DW-1:0] rb_q;
   logic          match;
   logic          give_up;

   assign match   = (rb_q == rd_data);
   assign give_up = (tries_q == TRY_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= PV_IDLE;
         idx_q   <= '0;
         tries_q <= '0;
         rb_q    <= '0;
      end else begin
         case (st_q)
            PV_IDLE: begin
               if (start) begin
                  idx_q   <= '0;
                  tries_q <= '0;
                  st_q    <= PV_WR;
               end
            end
            PV_WR: begin
               if (arr_ack) begin
                  tries_q <= tries_q + TW'(1);
                  st_q    <= PV_RD;
               end
            end
            PV_RD: begin
               if (arr_ack) begin
                  rb_q <= arr_rdata;
                  st_q <= PV_CHK;
               end
            end
            PV_CHK: begin
               if (match || give_up) begin
                  tries_q <= '0;
                  if (idx_q == LAST_IDX) begin
                     st_q <= PV_IDLE;
                  end else begin
                     idx_q <= idx_q + IW'(1);
                     st_q  <= PV_WR;
                  end
               end else begin
                  st_q <= PV_WR;
               end
            end
            default: st_q <= PV_IDLE;
         endcase
      end
   end

   assign rd_idx    = idx_q;
   assign arr_req   = (st_q == PV_WR) || (st_q == PV_RD);
   assign arr_we    = (st_q == PV_WR);
   assign arr_addr  = base_addr + AW'(idx_q);
   assign arr_wdata = rd_data;
   assign done      = (st_q == PV_CHK) && (match || give_up) && (idx_q == LAST_IDX);
   assign fail      = (st_q == PV_CHK) && !match && give_up;

endmodule

// File: rtl/fpgm_seq.sv
module fpgm_seq
   import fpgm_pkg::*;
#(
   parameter int AW        = 20,
   parameter int DW        = 16,
   parameter int BUF_WORDS = 32,
   parameter int BLK_BITS  = 16,
   parameter int MAX_TRIES = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_enter,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [7:0]    status,
   output logic          arr_req,
   output logic          arr_we,
   output logic [AW-1:0] arr_addr,
   output logic [DW-1:0] arr_wdata,
   input  logic          arr_ack,
   input  logic [DW-1:0] arr_rdata
);

   localparam int IW = $clog2(BUF_WORDS);
   localparam int HW = AW - BLK_BITS;
   localparam logic [IW-1:0] LAST_SLOT = IW'(BUF_WORDS - 1);

   if (BUF_WORDS < 2 || (BUF_WORDS & (BUF_WORDS - 1)) != 0) begin : g_bad_depth
      $error("BUF_WORDS must be a power of two of at least 2");
   end
   if (BLK_BITS < 1 || BLK_BITS >= AW) begin : g_bad_blk
      $error("BLK_BITS must lie in 1..AW-1");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("MAX_TRIES must be at least 1");
   end

   seq_st_t       st_q;
   logic [AW-1:0] start_q;
   logic [AW-1:0] offs_q;
   logic [IW-1:0] cnt_q;
   logic          seq_err_q;
   logic          fail_q;

   logic          same_blk;
   logic          buf_we;
   logic [IW-1:0] buf_ridx;
   logic [DW-1:0] buf_rdata;
   logic          pv_done;
   logic          pv_fail;

   fpgm_blkcmp #(.HW(HW)) u_blk (
      .hi_a (bus_addr[AW-1:BLK_BITS]),
      .hi_b (start_q[AW-1:BLK_BITS]),
      .same (same_blk)
   );

   assign buf_we = bus_wr && ((st_q == SQ_FIRST) || (st_q == SQ_FILL && same_blk));

   fpgm_wbuf #(.DW(DW), .DEPTH(BUF_WORDS)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (buf_we),
      .wr_idx  (cnt_q),
      .wr_data (bus_wdata),
      .rd_idx  (buf_ridx),
      .rd_data (buf_rdata)
   );

   fpgm_pv #(
      .AW        (AW),
      .DW        (DW),
      .DEPTH     (BUF_WORDS),
      .MAX_TRIES (MAX_TRIES)
   ) u_pv (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (st_q == SQ_PROG),
      .base_addr (start_q + offs_q),
      .rd_idx    (buf_ridx),
      .rd_data   (buf_rdata),
      .arr_req   (arr_req),
      .arr_we    (arr_we),
      .arr_addr  (arr_addr),
      .arr_wdata (arr_wdata),
      .arr_ack   (arr_ack),
      .arr_rdata (arr_rdata),
      .done      (pv_done),
      .fail      (pv_fail)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= SQ_OFF;
         start_q   <= '0;
         offs_q    <= '0;
         cnt_q     <= '0;
         seq_err_q <= 1'b0;
         fail_q    <= 1'b0;
      end else begin
         if (pv_fail)
            fail_q <= 1'b1;
         case (st_q)
            SQ_OFF: begin
               if (mode_enter) begin
                  st_q      <= SQ_FIRST;
                  offs_q    <= '0;
                  cnt_q     <= '0;
                  seq_err_q <= 1'b0;
                  fail_q    <= 1'b0;
               end
            end
            SQ_FIRST: begin
               if (bus_wr) begin
                  start_q <= bus_addr;
                  cnt_q   <= IW'(1);
                  st_q    <= SQ_FILL;
               end
            end
            SQ_FILL: begin
               if (bus_wr) begin
                  if (!same_blk) begin
                     st_q  <= SQ_OFF;
                     cnt_q <= '0;
                  end else if (cnt_q == LAST_SLOT) begin
                     st_q  <= SQ_PROG;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + IW'(1);
                  end
               end
            end
            SQ_PROG: begin
               if (bus_wr)
                  seq_err_q <= 1'b1;
               if (pv_done) begin
                  st_q   <= SQ_FILL;
                  offs_q <= offs_q + AW'(BUF_WORDS);
               end
            end
            default: st_q <= SQ_OFF;
         endcase
      end
   end

   always_comb begin
      status          = '0;
      status[SB_BUSY] = (st_q == SQ_PROG);
      status[SB_SEQ]  = seq_err_q;
      status[SB_FAIL] = fail_q;
      status[SB_EXIT] = (st_q == SQ_OFF);
   end

endmodule

// File: rtl/fpgm_seq_chk.sv
module fpgm_seq_chk #(
   parameter int AW = 20,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mode_enter,
   input logic [7:0]    status,
   input logic          arr_req,
   input logic          arr_we,
   input logic [AW-1:0] arr_addr,
   input logic [DW-1:0] arr_wdata,
   input logic          arr_ack
);

   // R11: request fields held until acknowledged
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_req && !arr_ack) |=> (arr_req && $stable(arr_we) && $stable(arr_addr) && $stable(arr_wdata)));

   // R3: array traffic only while busy is shown
   a_r3_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      arr_req |-> status[0]);

   // R1 / R8: exit state never reports busy
   a_r8_exit_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] |-> !status[0]);

   // R6: failure flag is sticky within a mode session
   a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[4] && !mode_enter) |=> status[4]);

   // R7: sequence-error flag is sticky within a mode session
   a_r7_seq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[3] && !mode_enter) |=> status[3]);

   // R9: without an entry pulse the exit state is kept
   a_r9_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && !mode_enter) |=> (status[7] && $stable(status)));

   // R10: entry clears all status bits
   a_r10_entry_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && mode_enter) |=> (status == 8'h00));

endmodule

bind fpgm_seq fpgm_seq_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_enter (mode_enter),
   .status     (status),
   .arr_req    (arr_req),
   .arr_we     (arr_we),
   .arr_addr   (arr_addr),
   .arr_wdata  (arr_wdata),
   .arr_ack    (arr_ack)
);

// File: tb/tb_fpgm_seq.sv
module tb_fpgm_seq;

   localparam int AW = 20;
   localparam int DW = 16;
   localparam logic [AW-1:0] S_ADDR  = 20'h30100;
   localparam logic [AW-1:0] FLAKY_A = S_ADDR + 20'd35;
   localparam logic [AW-1:0] STUCK_A = S_ADDR + 20'd100;
   localparam logic [AW-1:0] T_ADDR  = 20'h50000;
   // fill vectors: {seed[15:0], real word count[7:0], address jitter[15:0]}
   localparam logic [39:0] FILLS [3] = '{
      {16'hC3A0, 8'd32, 16'h0000},
      {16'h5A00, 8'd20, 16'h0000},
      {16'h0F0F, 8'd32, 16'h0007}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_enter = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [7:0]    status;
   logic          arr_req, arr_we, arr_ack;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_wdata, arr_rdata;

   int checks = 0;
   int fails = 0;
   int prog_ops = 0;
   int flaky_ops = 0;
   int stuck_ops = 0;
   bit finished = 1'b0;

   logic [DW-1:0] mem [logic [AW-1:0]];

   always #2 clk = ~clk;

   fpgm_seq dut (
      .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status(status),
      .arr_req(arr_req), .arr_we(arr_we), .arr_addr(arr_addr),
      .arr_wdata(arr_wdata), .arr_ack(arr_ack), .arr_rdata(arr_rdata)
   );

   function automatic logic [DW-1:0] mrd(input logic [AW-1:0] a);
      logic [DW-1:0] v;
      v = mem.exists(a) ? mem[a] : 16'hFFFF;
      if (a == STUCK_A) v = v & 16'hFFFE;
      return v;
   endfunction

   // behavioural array: one-cycle acknowledge, program only clears bits
   initial begin
      arr_ack = 1'b0;
      arr_rdata = '0;
      forever begin
         @(posedge clk);
         if (arr_req && !arr_ack) begin
            arr_ack <= 1'b1;
            if (arr_we) begin
               prog_ops++;
               if (arr_addr == STUCK_A) stuck_ops++;
               if (arr_addr == FLAKY_A) begin
                  flaky_ops++;
                  if (flaky_ops > 2) mem[arr_addr] = mrd(arr_addr) & arr_wdata;
               end else begin
                  mem[arr_addr] = mrd(arr_addr) & arr_wdata;
               end
            end else begin
               arr_rdata <= mrd(arr_addr);
            end
         end else begin
            arr_ack <= 1'b0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bwrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poll);
      if (poll) while (status[0]) @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic wait_ready();
      @(negedge clk);
      while (status[0]) @(negedge clk);
   endtask

   function automatic logic [DW-1:0] fdat(input logic [15:0] seed, input int i, input int nreal);
      return (i < nreal) ? (seed ^ DW'(i * 16'h0111)) : 16'hFFFF;
   endfunction

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int bad;
      int ops0;
      logic [7:0] st0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(status == 8'h80, "R1 reset status", status, 8'h80);
      chk(!arr_req, "R1 no request", arr_req, 0);

      mode_enter = 1'b1; @(negedge clk); mode_enter = 1'b0;
      chk(status == 8'h00, "R2 mode entered", status, 8'h00);

      // table-driven fills: R2 R3 R4 R5 R12
      for (int f = 0; f < 3; f++) begin
         logic [15:0] seed, jit;
         int nreal;
         seed  = FILLS[f][39:24];
         nreal = int'(FILLS[f][23:16]);
         jit   = FILLS[f][15:0];
         for (int i = 0; i < 32; i++) begin
            logic [AW-1:0] a;
            a = {S_ADDR[19:16], S_ADDR[15:0] ^ 16'(i * jit)};
            bwrite(a, fdat(seed, i, nreal), 1'b1);
            if (i == 31) chk(status[0] == 1'b1, "R3 busy after slot 31", status, 1);
         end
         wait_ready();
         bad = 0;
         for (int i = 0; i < 32; i++)
            if (mrd(S_ADDR + AW'(32 * f + i)) != fdat(seed, i, nreal)) bad++;
         chk(bad == 0, (f == 2) ? "R4 jittered fill" : "R3 R5 R12 fill contents", bad, 0);
         chk(status == 8'h00, "R5 ready again", status, 8'h00);
      end
      chk(mrd(S_ADDR + 20'd60) == 16'hFFFF, "R12 filler erased", mrd(S_ADDR + 20'd60), 16'hFFFF);
      chk(flaky_ops == 3, "R6 reprogram count", flaky_ops, 3);
      chk(mrd(FLAKY_A) == fdat(16'h5A00, 3, 20), "R6 reprogram recovers", mrd(FLAKY_A), fdat(16'h5A00, 3, 20));

      // stuck word plus a write while busy: R6 R7
      for (int i = 0; i < 32; i++)
         bwrite(S_ADDR, (i == 4) ? 16'hFFFF : 16'h1230 + 16'(i), 1'b1);
      bwrite(S_ADDR, 16'hDEAD, 1'b0);
      wait_ready();
      chk(stuck_ops == 4, "R6 retry limit", stuck_ops, 4);
      chk(status == 8'h18, "R6 R7 sticky bits", status, 8'h18);
      chk(mrd(S_ADDR + 20'd101) == 16'h1235, "R6 continues after fail", mrd(S_ADDR + 20'd101), 16'h1235);

      for (int i = 0; i < 32; i++) bwrite(S_ADDR, 16'h7700 + 16'(i), 1'b1);
      wait_ready();
      chk(mrd(S_ADDR + 20'd128) == 16'h7700, "R7 busy write not stored", mrd(S_ADDR + 20'd128), 16'h7700);
      chk(mrd(S_ADDR + 20'd159) == 16'h771F, "R7 counter unchanged", mrd(S_ADDR + 20'd159), 16'h771F);

      // partial fill then leave the block: R8
      ops0 = prog_ops;
      for (int i = 0; i < 5; i++) bwrite(S_ADDR, 16'h0000, 1'b1);
      bwrite(20'h40000, 16'h0000, 1'b1);
      repeat (20) @(negedge clk);
      chk(status == 8'h98, "R8 exit status", status, 8'h98);
      chk(prog_ops == ops0, "R8 partial dropped", prog_ops, ops0);
      chk(mrd(S_ADDR + 20'd160) == 16'hFFFF, "R8 no store", mrd(S_ADDR + 20'd160), 16'hFFFF);

      // writes outside the mode: R9
      st0 = status;
      for (int i = 0; i < 40; i++) bwrite(S_ADDR, 16'h0000, 1'b0);
      repeat (20) @(negedge clk);
      chk(prog_ops == ops0, "R9 no array ops", prog_ops, ops0);
      chk(status == st0, "R9 status unchanged", status, st0);

      // re-entry clears sticky bits, new start address: R10 R2
      mode_enter = 1'b1; @(negedge clk); mode_enter = 1'b0;
      chk(status == 8'h00, "R10 sticky cleared", status, 8'h00);
      for (int i = 0; i < 32; i++) bwrite(T_ADDR, (i == 0) ? 16'h1111 : 16'h2200 + 16'(i), 1'b1);
      wait_ready();
      chk(mrd(T_ADDR) == 16'h1111, "R2 first word at start", mrd(T_ADDR), 16'h1111);
      chk(mrd(T_ADDR + 20'd31) == 16'h221F, "R2 offset restarts", mrd(T_ADDR + 20'd31), 16'h221F);
      bwrite(20'h60000, 16'h0, 1'b1);
      @(negedge clk);
      chk(status == 8'h80, "R8 second exit", status, 8'h80);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule